// File: doc/BRIEF.md
# Command-Scripted Stream Beat Generator

This block is a stream producer that plays out a short script of commands on a ready/valid data stream. Commands arrive over a valid/ready command port and wait in a small queue. Each command is one of three kinds. A single beat carries a given data word and a given end-of-packet flag. A burst emits a counted run of beats whose data starts at a given value, counts up by one on each accepted beat, and carries the end-of-packet flag only on its final beat. A pause holds the stream idle for a given number of clock edges.

The engine drives registered stream outputs. It respects downstream backpressure and keeps the presented beat frozen until it is accepted. When one command finishes, the engine loads the next queued command on the same clock edge, so consecutive commands follow each other without idle cycles. Commands that would have no effect are dropped when they enter the queue, so they cost no cycles. An idle flag tells the surrounding logic that the script has been played out.

Top module: `strm_cmd_source`

## Requirements
- R1: While reset is applied and just after it, m_tdata is 0, m_tstrb is 4'b1111, m_tlast is 0, m_tvalid is 0, idle is 1 and cmd_ready is 1. m_tstrb stays 4'b1111 at all times.
- R2: A single-beat command (cmd_op 2'b00) emits exactly one beat whose data is cmd_data and whose m_tlast equals cmd_last. cmd_len is ignored.
- R3: A burst command (cmd_op 2'b01) with cmd_len = N > 0 emits N beats with data cmd_data, cmd_data+1, ... (modulo 2^32). m_tlast is 1 only on the Nth beat.
- R4: A pause command (cmd_op 2'b10) with cmd_len = D > 0 keeps m_tvalid and m_tlast at 0 for exactly D rising edges. So a beat accepted just before a pause and a beat accepted just after it are D+1 edges apart when m_tready is held high.
- R5: Commands run in the order they were accepted. The first beat of a command is presented on the same edge on which the previous command finishes, so no idle cycle separates them.
- R6: While m_tvalid is 1 and m_tready is 0, m_tvalid, m_tdata and m_tlast keep their values on the next edge.
- R7: A burst with cmd_len 0, a pause with cmd_len 0, and the reserved opcode 2'b11 are accepted on the command port but emit no beat and add no cycle to the stream.
- R8: idle is 1 exactly when no command is queued or running, and m_tvalid is 0 while idle is 1. With an idle engine and m_tready high, the first beat of a command accepted on edge A is transferred on edge A+2.
- R9: The queue holds CMD_DEPTH commands in addition to the one running. cmd_ready is 0 when the queue is full, and a command offered while cmd_ready is 0 is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command queue has room |
| cmd_op | input | 2 | 00 single, 01 burst, 10 pause, 11 reserved |
| cmd_data | input | 32 | Beat data or burst start value |
| cmd_last | input | 1 | End-of-packet flag for a single beat |
| cmd_len | input | 16 | Burst beat count or pause length in edges |
| m_tdata | output | 32 | Stream data |
| m_tstrb | output | 4 | Byte qualifiers, always all ones |
| m_tlast | output | 1 | End of packet |
| m_tvalid | output | 1 | Beat presented |
| m_tready | input | 1 | Downstream accepts beat |
| idle | output | 1 | Nothing queued or running |

## Verification
A command accepted on edge A reaches the engine on A+1, and its first beat is transferred on A+2 when the stream is ready. After that, each following command presents its first beat on the very edge at which its predecessor's last beat transfers or its pause count expires. A pause of D therefore spaces the surrounding transfers D+1 edges apart. The bench stamps every transfer with the index of the rising edge at which it occurs, reading the outputs at that edge before any register updates. It changes all inputs on falling edges and compares the stamps against these edge offsets instead of against wall-clock delays. Scenarios that depend on spacing first fill the queue with the stream stalled, then release m_tready on a falling edge, so the expected edge of every later transfer is fixed.

// File: rtl/strm_cmd_pkg.sv
package strm_cmd_pkg;

    localparam int DATA_W = 32;
    localparam int LEN_W  = 16;
    localparam int STRB_W = DATA_W / 8;

    typedef enum logic [1:0] {
        OP_SINGLE = 2'b00,
        OP_BURST  = 2'b01,
        OP_PAUSE  = 2'b10,
        OP_RSVD   = 2'b11
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [DATA_W-1:0] data;
        logic              last;
        logic [LEN_W-1:0]  len;
    } cmd_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_BEAT = 2'b01,
        ST_GAP  = 2'b10
    } st_e;

    typedef struct packed {
        st_e               st;
        logic              valid;
        logic [DATA_W-1:0] data;
        logic              last;
        logic [LEN_W-1:0]  cnt;
    } eng_t;

endpackage

// File: rtl/strm_cmd_screen.sv
module strm_cmd_screen
    import strm_cmd_pkg::*;
(
    input  cmd_t cmd,
    output logic keep
);
    // Only commands that change the stream are worth a queue slot.
    always_comb begin
        case (cmd.op)
            OP_SINGLE: keep = 1'b1;
            OP_BURST:  keep = (cmd.len != '0);
            OP_PAUSE:  keep = (cmd.len != '0);
            default:   keep = 1'b0;
        endcase
    end
endmodule

// File: rtl/strm_cmd_fifo.sv
module strm_cmd_fifo
    import strm_cmd_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  cmd_t wr_cmd,
    output logic full,
    input  logic rd_en,
    output cmd_t rd_cmd,
    output logic rd_avail
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic wr_ok, rd_ok;
    cmd_t slot_w [DEPTH];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full     = (ctl_q.cnt == CW'(DEPTH));
    assign rd_avail = (ctl_q.cnt != '0);
    assign rd_cmd   = slot_w[ctl_q.rp];

    always_comb begin
        ctl_d = ctl_q;
        wr_ok = wr_en && !full;
        rd_ok = rd_en && rd_avail;
        if (wr_ok) ctl_d.wp = bump(ctl_q.wp);
        if (rd_ok) ctl_d.rp = bump(ctl_q.rp);
        case ({wr_ok, rd_ok})
            2'b10:   ctl_d.cnt = ctl_q.cnt + 1'b1;
            2'b01:   ctl_d.cnt = ctl_q.cnt - 1'b1;
            default: ctl_d.cnt = ctl_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        cmd_t ent_q;
        always_ff @(posedge clk) begin
            if (wr_ok && ctl_q.wp == PW'(i)) ent_q <= wr_cmd;
        end
        assign slot_w[i] = ent_q;
    end
endmodule

// File: rtl/strm_cmd_engine.sv
module strm_cmd_engine
    import strm_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_t              head,
    input  logic              head_valid,
    output logic              pop,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last,
    output logic              busy
);
    eng_t eng_d, eng_q;
    logic finish;

    // Next state when a command is taken from the queue head.
    function automatic eng_t launch(input cmd_t c, input eng_t cur);
        eng_t n;
        n = cur;
        case (c.op)
            OP_SINGLE: begin
                n.st    = ST_BEAT;
                n.valid = 1'b1;
                n.data  = c.data;
                n.last  = c.last;
                n.cnt   = LEN_W'(1);
            end
            OP_BURST: begin
                n.st    = ST_BEAT;
                n.valid = 1'b1;
                n.data  = c.data;
                n.last  = (c.len == LEN_W'(1));
                n.cnt   = c.len;
            end
            default: begin
                n.st    = ST_GAP;
                n.valid = 1'b0;
                n.last  = 1'b0;
                n.cnt   = c.len;
            end
        endcase
        return n;
    endfunction

    always_comb begin
        eng_d  = eng_q;
        finish = 1'b0;
        pop    = 1'b0;
        case (eng_q.st)
            ST_BEAT: begin
                if (out_ready) begin
                    if (eng_q.cnt == LEN_W'(1)) begin
                        finish = 1'b1;
                    end else begin
                        eng_d.cnt  = eng_q.cnt - 1'b1;
                        eng_d.data = eng_q.data + DATA_W'(1);
                        eng_d.last = (eng_q.cnt == LEN_W'(2));
                    end
                end
            end
            ST_GAP: begin
                if (eng_q.cnt == LEN_W'(1)) finish = 1'b1;
                else                        eng_d.cnt = eng_q.cnt - 1'b1;
            end
            default: finish = 1'b1;
        endcase
        if (finish) begin
            if (head_valid) begin
                pop   = 1'b1;
                eng_d = launch(head, eng_q);
            end else begin
                eng_d.st    = ST_IDLE;
                eng_d.valid = 1'b0;
                eng_d.last  = 1'b0;
                eng_d.cnt   = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_q.st    <= ST_IDLE;
            eng_q.valid <= 1'b0;
            eng_q.data  <= '0;
            eng_q.last  <= 1'b0;
            eng_q.cnt   <= '0;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign out_valid = eng_q.valid;
    assign out_data  = eng_q.data;
    assign out_last  = eng_q.last;
    assign busy      = (eng_q.st != ST_IDLE);
endmodule

// File: rtl/strm_cmd_source.sv
module strm_cmd_source
    import strm_cmd_pkg::*;
#(
    parameter int CMD_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              cmd_last,
    input  logic [LEN_W-1:0]  cmd_len,
    output logic [DATA_W-1:0] m_tdata,
    output logic [STRB_W-1:0] m_tstrb,
    output logic              m_tlast,
    output logic              m_tvalid,
    input  logic              m_tready,
    output logic              idle
);
    cmd_t in_cmd, head_cmd;
    logic keep, q_full, q_avail, q_pop, eng_busy;

    assign in_cmd = '{op: op_e'(cmd_op), data: cmd_data, last: cmd_last, len: cmd_len};

    strm_cmd_screen screen_i (
        .cmd  (in_cmd),
        .keep (keep)
    );

    strm_cmd_fifo #(.DEPTH(CMD_DEPTH)) fifo_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cmd_valid && keep),
        .wr_cmd   (in_cmd),
        .full     (q_full),
        .rd_en    (q_pop),
        .rd_cmd   (head_cmd),
        .rd_avail (q_avail)
    );

    strm_cmd_engine engine_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .head       (head_cmd),
        .head_valid (q_avail),
        .pop        (q_pop),
        .out_ready  (m_tready),
        .out_valid  (m_tvalid),
        .out_data   (m_tdata),
        .out_last   (m_tlast),
        .busy       (eng_busy)
    );

    assign cmd_ready = !q_full;
    assign m_tstrb   = '1;
    assign idle      = !eng_busy && !q_avail;
endmodule

// File: rtl/strm_cmd_source_chk.sv
module strm_cmd_source_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] m_tdata,
    input logic [3:0]  m_tstrb,
    input logic        m_tlast,
    input logic        m_tvalid,
    input logic        m_tready,
    input logic        idle
);
    logic rst_seen;

    always_ff @(posedge clk) begin
        rst_seen <= (rst_seen === 1'b1) || !rst_n;
    end

    always @(negedge clk) begin
        if (!rst_n && rst_seen === 1'b1) begin
            AST_RESET_OUT: assert (!m_tvalid && !m_tlast && m_tdata == '0 && m_tstrb == 4'hF && idle) // R1
                else $error("reset output state wrong");
        end
    end

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=> ($stable(m_tdata) && $stable(m_tlast))) // R6
        else $error("stalled beat changed");

    AST_VALID_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=> m_tvalid) // R6
        else $error("valid dropped before transfer");

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !m_tvalid) // R8
        else $error("valid while idle");

    AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        m_tlast |-> m_tvalid) // R4
        else $error("last without valid");
endmodule

bind strm_cmd_source strm_cmd_source_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .m_tdata  (m_tdata),
    .m_tstrb  (m_tstrb),
    .m_tlast  (m_tlast),
    .m_tvalid (m_tvalid),
    .m_tready (m_tready),
    .idle     (idle)
);

// File: tb/strm_cmd_source_tb_top.sv
module strm_cmd_source_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_op = 2'b00;
    logic [31:0] cmd_data = '0;
    logic        cmd_last = 1'b0;
    logic [15:0] cmd_len = '0;
    logic [31:0] m_tdata;
    logic [3:0]  m_tstrb;
    logic        m_tlast, m_tvalid, m_tready, idle;

    logic bp_mode = 1'b0;
    logic rdy_lvl = 1'b1;
    logic bp_bit  = 1'b1;

    always #10 clk = ~clk;

    assign m_tready = bp_mode ? bp_bit : rdy_lvl;

    strm_cmd_source dut_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .cmd_last(cmd_last), .cmd_len(cmd_len),
        .m_tdata(m_tdata), .m_tstrb(m_tstrb), .m_tlast(m_tlast),
        .m_tvalid(m_tvalid), .m_tready(m_tready), .idle(idle)
    );

    int n_chk = 0;
    int n_fail = 0;
    int edge_no = 0;

    logic [31:0] bq_data [$];
    logic        bq_last [$];
    int          bq_edge [$];

    int          stall_cnt = 0;
    int          stall_bad = 0;
    logic        pv_stall = 1'b0;
    logic [31:0] pv_data;
    logic        pv_last;

    // Transfer monitor: values read at the edge, before registers update.
    always @(posedge clk) begin
        edge_no++;
        if (rst_n) begin
            if (pv_stall) begin
                stall_cnt++;
                if (!m_tvalid || m_tdata != pv_data || m_tlast != pv_last) stall_bad++;
            end
            if (m_tvalid && m_tready) begin
                bq_data.push_back(m_tdata);
                bq_last.push_back(m_tlast);
                bq_edge.push_back(edge_no);
            end
            pv_stall = m_tvalid && !m_tready;
            pv_data  = m_tdata;
            pv_last  = m_tlast;
        end else begin
            pv_stall = 1'b0;
        end
    end

    always @(negedge clk) bp_bit <= ((edge_no % 3) != 1);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the falling edge after acceptance.
    task automatic send(input logic [1:0] op, input logic [31:0] d, input logic l,
                        input logic [15:0] n, output int acc);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_data  = d;
        cmd_last  = l;
        cmd_len   = n;
        do @(posedge clk); while (!cmd_ready);
        @(negedge clk);
        acc = edge_no;
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int k = 0;
        @(negedge clk);
        while (!idle && k < 2000) begin
            @(negedge clk);
            k++;
        end
        chk({req, " reaches idle"}, {31'd0, idle}, 32'd1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 tvalid", {31'd0, m_tvalid}, 32'd0);
        chk("R1 tdata", m_tdata, 32'd0);
        chk("R1 tstrb", {28'd0, m_tstrb}, 32'hF);
        chk("R1 tlast", {31'd0, m_tlast}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle", {31'd0, idle}, 32'd1);
        chk("R1 cmd_ready", {31'd0, cmd_ready}, 32'd1);
        chk("R1 tvalid after release", {31'd0, m_tvalid}, 32'd0);
    endtask

    task automatic t_single();
        int base, acc;
        bp_mode = 1'b0;
        rdy_lvl = 1'b1;
        base = bq_data.size();
        send(2'b00, 32'hA5A5_0001, 1'b1, 16'd9, acc);
        wait_idle("R2");
        chk("R2 beat count", bq_data.size() - base, 1);
        chk("R2 data", bq_data[base], 32'hA5A5_0001);
        chk("R2 last copied 1", {31'd0, bq_last[base]}, 32'd1);
        chk("R8 first beat two edges after accept", bq_edge[base], acc + 2);
        chk("R1 tstrb all ones", {28'd0, m_tstrb}, 32'hF);
        base = bq_data.size();
        send(2'b00, 32'h0000_1234, 1'b0, 16'd3, acc);
        wait_idle("R2");
        chk("R2 beat count flag 0", bq_data.size() - base, 1);
        chk("R2 last copied 0", {31'd0, bq_last[base]}, 32'd0);
        chk("R8 tvalid low when idle", {31'd0, m_tvalid}, 32'd0);
    endtask

    task automatic t_burst_bp();
        int base, acc, s0;
        s0 = stall_cnt;
        base = bq_data.size();
        bp_mode = 1'b1;
        send(2'b01, 32'hFFFF_FFFE, 1'b0, 16'd5, acc);
        wait_idle("R3");
        bp_mode = 1'b0;
        chk("R3 burst beat count", bq_data.size() - base, 5);
        for (int i = 0; i < 5; i++) begin
            if (base + i < bq_data.size()) begin
                chk("R3 burst data", bq_data[base + i], 32'hFFFF_FFFE + 32'(i));
                chk("R3 burst last", {31'd0, bq_last[base + i]}, (i == 4) ? 32'd1 : 32'd0);
            end
        end
        chk("R6 stalls occurred", {31'd0, stall_cnt > s0}, 32'd1);
        chk("R6 stalled beat held", stall_bad, 0);
    endtask

    task automatic t_pause();
        int base, acc;
        bp_mode = 1'b0;
        rdy_lvl = 1'b0;
        base = bq_data.size();
        send(2'b00, 32'd11, 1'b0, 16'd0, acc);
        send(2'b10, 32'd0, 1'b1, 16'd3, acc);
        send(2'b00, 32'd22, 1'b0, 16'd0, acc);
        send(2'b10, 32'd0, 1'b0, 16'd1, acc);
        send(2'b00, 32'd33, 1'b1, 16'd0, acc);
        rdy_lvl = 1'b1;
        wait_idle("R4");
        chk("R4 beat count", bq_data.size() - base, 3);
        if (bq_data.size() - base == 3) begin
            chk("R4 order", bq_data[base + 1], 32'd22);
            chk("R4 pause of 3 spacing", bq_edge[base + 1] - bq_edge[base], 4);
            chk("R4 pause of 1 spacing", bq_edge[base + 2] - bq_edge[base + 1], 2);
        end
    endtask

    task automatic t_nogap();
        int base, acc;
        logic [31:0] ed [6] = '{32'd100, 32'd101, 32'd102, 32'd200, 32'd300, 32'd301};
        logic        el [6] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
        rdy_lvl = 1'b0;
        base = bq_data.size();
        send(2'b01, 32'd100, 1'b0, 16'd3, acc);
        send(2'b00, 32'd200, 1'b1, 16'd0, acc);
        send(2'b01, 32'd300, 1'b0, 16'd2, acc);
        rdy_lvl = 1'b1;
        wait_idle("R5");
        chk("R5 beat count", bq_data.size() - base, 6);
        if (bq_data.size() - base == 6) begin
            for (int i = 0; i < 6; i++) begin
                chk("R5 order data", bq_data[base + i], ed[i]);
                chk("R3 last placement", {31'd0, bq_last[base + i]}, {31'd0, el[i]});
            end
            chk("R5 back-to-back edges", bq_edge[base + 5] - bq_edge[base], 5);
        end
    endtask

    task automatic t_discard();
        int base, acc;
        rdy_lvl = 1'b0;
        base = bq_data.size();
        send(2'b00, 32'd1, 1'b0, 16'd0, acc);
        send(2'b01, 32'd77, 1'b1, 16'd0, acc);
        send(2'b10, 32'd0, 1'b0, 16'd0, acc);
        send(2'b11, 32'd88, 1'b1, 16'd5, acc);
        send(2'b00, 32'd2, 1'b1, 16'd0, acc);
        rdy_lvl = 1'b1;
        wait_idle("R7");
        chk("R7 only real beats", bq_data.size() - base, 2);
        if (bq_data.size() - base == 2) begin
            chk("R7 second beat data", bq_data[base + 1], 32'd2);
            chk("R7 no added cycle", bq_edge[base + 1] - bq_edge[base], 1);
        end
    endtask

    task automatic t_full();
        int base, acc;
        rdy_lvl = 1'b0;
        base = bq_data.size();
        for (int i = 0; i < 5; i++) send(2'b00, 32'd10 + 32'(i), 1'b0, 16'd0, acc);
        chk("R9 ready low when full", {31'd0, cmd_ready}, 32'd0);
        chk("R8 idle low while busy", {31'd0, idle}, 32'd0);
        cmd_valid = 1'b1;
        cmd_op    = 2'b00;
        cmd_data  = 32'd99;
        repeat (3) @(negedge clk);
        cmd_valid = 1'b0;
        chk("R9 still full", {31'd0, cmd_ready}, 32'd0);
        rdy_lvl = 1'b1;
        wait_idle("R9");
        chk("R9 rejected command not taken", bq_data.size() - base, 5);
        if (bq_data.size() - base == 5) begin
            chk("R9 last queued data", bq_data[base + 4], 32'd14);
        end
        chk("R8 idle tvalid low", {31'd0, m_tvalid}, 32'd0);
        chk("R9 ready after drain", {31'd0, cmd_ready}, 32'd1);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_single();
        t_burst_bp();
        t_pause();
        t_nogap();
        t_discard();
        t_full();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule